// File: doc/BRIEF.md
# Logarithmic-Domain Multiply-Accumulate Unit

This block computes dot products whose elements are 8-bit logarithmic numbers. Each element holds a sign bit and a 7-bit base-2 logarithm stored as unsigned fixed point. A per-operand select picks a split of 4 integer and 3 fraction bits, or 5 integer and 2 fraction bits. The two operands of a pair are multiplied by adding their logarithms. To divide, the second logarithm is subtracted instead. Neither operation needs a multiplier array.

The sum of the logarithms is split into an integer part and a 3-bit fraction. The fraction indexes a small constant table that holds the linear mantissa. The integer part becomes a binary exponent. The resulting linear product is added into a wide floating-point running sum, with alignment, sticky bits, round-to-nearest-even and renormalisation.

Operand pairs arrive on a valid/ready stream. A clear input starts a new reduction. The running sum is always visible on the outputs, and a valid flag is high whenever the sum includes every accepted pair.

Top module: `lns_mac`

## Requirements
- R1: An operand code holds its sign in bit 7 and its log field L in bits 6..0. With select 0 the value is 2^(L/8 - 8); with select 1 it is 2^(L/4 - 16). Before the add, both are brought to a common point with 3 fraction bits, so formats may be mixed within a pair.
- R2: For a multiply, the product logarithm P is the sum of the two operand logarithms, and the product sign is the XOR of the operand signs. The product value is 2^floor(P) * M[frac(P)*8] / 64.
- R3: With the divide flag set, the second operand's logarithm is negated before the add, and the sign rule of R2 is unchanged.
- R4: The mantissa table M, indexed by the 3 fraction bits of P from 0 to 7, holds 64, 70, 76, 83, 91, 99, 108, 117.
- R5: A log field of zero is an exact zero when the sign is 0, and an unsigned infinity when the sign is 1. For a multiply, any infinity gives infinity, and otherwise any zero gives zero. For a divide, the checks are taken in this order: an infinite dividend gives infinity, then a zero divisor gives infinity, then a zero dividend gives zero, then an infinite divisor gives zero.
- R6: The sum appears as acc_sign, acc_exp and acc_mant. acc_exp carries a bias of 2^(EXP_W-1)-1. acc_mant has FRAC_W+1 bits, with the leading one at the top. The value is (-1)^acc_sign * acc_mant * 2^(acc_exp - bias - FRAC_W). A zero sum shows all three fields as 0. Infinity shows acc_inf = 1 with the other fields 0.
- R7: Sums whose exact result fits the mantissa are reproduced exactly, including a positive and a negative term that cancel to zero.
- R8: When a term does not fit the mantissa exactly, the sum is rounded to nearest, with ties going to the even mantissa.
- R9: Once infinity enters the sum, acc_inf stays 1 until a clear.
- R10: A clear empties the sum and discards a product still in flight. A pair accepted in the same cycle as the clear becomes the first term of the new sum.
- R11: in_ready is 1 from the first clock after reset. A pair accepted at clock edge k is in the sum after edge k+1. acc_valid is 0 between those two edges and 1 whenever no pair was accepted at the previous edge.
- R12: After reset the sum is zero, acc_inf is 0 and acc_valid is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clr | input | 1 | Start a new sum |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Pair can be taken |
| in_a | input | 8 | First operand (dividend) |
| in_b | input | 8 | Second operand (divisor) |
| in_fmt_a | input | 1 | Layout of in_a: 0 = 4.3, 1 = 5.2 |
| in_fmt_b | input | 1 | Layout of in_b: 0 = 4.3, 1 = 5.2 |
| in_div | input | 1 | Divide instead of multiply |
| acc_valid | output | 1 | Sum includes all accepted pairs |
| acc_inf | output | 1 | Sum is infinite |
| acc_sign | output | 1 | Sign of the sum |
| acc_exp | output | EXP_W | Biased exponent of the sum |
| acc_mant | output | FRAC_W+1 | Normalised mantissa of the sum |

## Verification
A clear and an accepted operand pair can fall in the same cycle. So can a clear and the retirement of a product still in flight. Every table vector is driven together with a clear, and the bench checks that the sum equals that pair's product alone. A separate test accepts one pair, then asserts clear with a different pair on the next cycle. It is judged correct only if the first product is absent from the final sum.

// File: rtl/lns_mac_pkg.sv
package lns_mac_pkg;
   localparam int OP_W  = 8;
   localparam int LOG_W = 7;
   localparam int LFRAC = 3;
   localparam int ROM_W = 7;
   localparam int UL_W  = 10;

   typedef enum logic [1:0] {
      K_NUM  = 2'd0,
      K_ZERO = 2'd1,
      K_INF  = 2'd2
   } kind_t;

   typedef struct packed {
      kind_t                   kind;
      logic                    sign;
      logic signed [UL_W-1:0]  ulog;
   } opnd_t;

   // linear mantissa 2^(f/8) scaled by 64
   function automatic logic [ROM_W-1:0] pow_rom(input logic [LFRAC-1:0] f);
      logic [ROM_W-1:0] r;
      case (f)
         3'd0: r = 7'd64;
         3'd1: r = 7'd70;
         3'd2: r = 7'd76;
         3'd3: r = 7'd83;
         3'd4: r = 7'd91;
         3'd5: r = 7'd99;
         3'd6: r = 7'd108;
         default: r = 7'd117;
      endcase
      return r;
   endfunction
endpackage

// File: rtl/lns_opnd_dec.sv
module lns_opnd_dec
   import lns_mac_pkg::*;
(
   input  logic [OP_W-1:0] code,
   input  logic            fmt,
   output opnd_t           opnd
);
   logic [LOG_W:0] aligned;

   always_comb begin
      aligned = fmt ? {code[LOG_W-1:0], 1'b0} : {1'b0, code[LOG_W-1:0]};
      opnd.sign = code[OP_W-1];
      if (code[LOG_W-1:0] == '0)
         opnd.kind = code[OP_W-1] ? K_INF : K_ZERO;
      else
         opnd.kind = K_NUM;
      // remove bias expressed in eighths: 8*8 or 16*8
      opnd.ulog = $signed({2'b00, aligned}) - (fmt ? 10'sd128 : 10'sd64);
   end
endmodule

// File: rtl/lns_prod.sv
module lns_prod
   import lns_mac_pkg::*;
#(
   parameter int EXP_W = 8
)
(
   input  opnd_t             a,
   input  opnd_t             b,
   input  logic              div,
   output kind_t             kind,
   output logic              sign,
   output logic [EXP_W-1:0]  exp,
   output logic [ROM_W-1:0]  mant
);
   localparam int EBIAS = (1 << (EXP_W-1)) - 1;
   localparam int PI_W  = UL_W - LFRAC;

   logic signed [UL_W-1:0] psum;
   logic signed [PI_W-1:0] pint;

   always_comb begin
      psum = div ? (a.ulog - b.ulog) : (a.ulog + b.ulog);
      pint = psum[UL_W-1:LFRAC];
      mant = pow_rom(psum[LFRAC-1:0]);
      exp  = EXP_W'(EBIAS + int'(pint));
      sign = a.sign ^ b.sign;
      if (!div) begin
         if (a.kind == K_INF || b.kind == K_INF)        kind = K_INF;
         else if (a.kind == K_ZERO || b.kind == K_ZERO) kind = K_ZERO;
         else                                           kind = K_NUM;
      end else begin
         if (a.kind == K_INF || b.kind == K_ZERO)       kind = K_INF;
         else if (a.kind == K_ZERO || b.kind == K_INF)  kind = K_ZERO;
         else                                           kind = K_NUM;
      end
   end
endmodule

// File: rtl/lns_accum.sv
module lns_accum
   import lns_mac_pkg::*;
#(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 16
)
(
   input  logic               clk,
   input  logic               rst,
   input  logic               clr,
   input  logic               p_valid,
   input  kind_t              p_kind,
   input  logic               p_sign,
   input  logic [EXP_W-1:0]   p_exp,
   input  logic [ROM_W-1:0]   p_mant,
   output logic               acc_inf,
   output logic               acc_sign,
   output logic [EXP_W-1:0]   acc_exp,
   output logic [FRAC_W:0]    acc_mant
);
   localparam int MW   = FRAC_W + 1;
   localparam int XW   = MW + 3;
   localparam int SH_W = $clog2(XW + 1);
   localparam int EW2  = EXP_W + 2;
   localparam int EMAX = (1 << EXP_W) - 2;

   function automatic logic [SH_W-1:0] lzc(input logic [XW-1:0] v);
      logic [SH_W-1:0] n;
      n = SH_W'(XW);
      for (int i = 0; i < XW; i++)
         if (v[i]) n = SH_W'(XW - 1 - i);
      return n;
   endfunction

   logic [MW-1:0]         add_m, m_big, m_sml, r_mant, n_mant;
   logic                  add_big, s_big, s_sml, lost, up;
   logic [EXP_W-1:0]      e_big, e_sml, dexp, r_exp, n_exp;
   logic [XW-1:0]         x_big, x_sml, x_shf, nrm;
   logic [XW:0]           raw;
   logic [SH_W-1:0]       lz;
   logic signed [EW2-1:0] re;
   logic [MW:0]           rnd;
   logic                  r_zero, r_inf, n_inf, n_sign;

   always_comb begin
      add_m   = {p_mant, {(MW-ROM_W){1'b0}}};
      add_big = (p_exp > acc_exp) || ((p_exp == acc_exp) && (add_m > acc_mant));
      if (add_big) begin
         e_big = p_exp;   m_big = add_m;    s_big = p_sign;
         e_sml = acc_exp; m_sml = acc_mant; s_sml = acc_sign;
      end else begin
         e_big = acc_exp; m_big = acc_mant; s_big = acc_sign;
         e_sml = p_exp;   m_sml = add_m;    s_sml = p_sign;
      end
      dexp  = e_big - e_sml;
      x_big = {m_big, 3'b000};
      x_sml = {m_sml, 3'b000};
      if (dexp >= EXP_W'(XW)) begin
         x_shf = '0;
         lost  = |m_sml;
      end else begin
         x_shf = x_sml >> dexp;
         lost  = |(x_sml & ~({XW{1'b1}} << dexp));
      end
      x_shf[0] = x_shf[0] | lost;
      raw = (s_big != s_sml) ? ({1'b0, x_big} - {1'b0, x_shf})
                             : ({1'b0, x_big} + {1'b0, x_shf});
      lz = '0;
      if (raw[XW]) begin
         nrm    = raw[XW:1];
         nrm[0] = nrm[0] | raw[0];
         re     = $signed({2'b00, e_big} + EW2'(1));
      end else begin
         lz  = lzc(raw[XW-1:0]);
         nrm = raw[XW-1:0] << lz;
         re  = $signed({2'b00, e_big} - {{(EW2-SH_W){1'b0}}, lz});
      end
      // round to nearest, ties to even
      up  = nrm[2] & (nrm[1] | nrm[0] | nrm[3]);
      rnd = {1'b0, nrm[XW-1:3]} + {{MW{1'b0}}, up};
      if (rnd[MW]) begin
         r_mant = rnd[MW:1];
         re     = $signed(re + EW2'(1));
      end else begin
         r_mant = rnd[MW-1:0];
      end
      r_zero = (raw == '0) || (re <= 0);
      r_inf  = !r_zero && (re > EMAX);
      r_exp  = re[EXP_W-1:0];
   end

   always_comb begin
      n_inf  = acc_inf;
      n_sign = acc_sign;
      n_exp  = acc_exp;
      n_mant = acc_mant;
      if (p_valid && !acc_inf) begin
         if (p_kind == K_INF) begin
            n_inf = 1'b1; n_sign = 1'b0; n_exp = '0; n_mant = '0;
         end else if (p_kind == K_NUM) begin
            if (acc_mant == '0) begin
               n_sign = p_sign; n_exp = p_exp; n_mant = add_m;
            end else if (r_inf) begin
               n_inf = 1'b1; n_sign = 1'b0; n_exp = '0; n_mant = '0;
            end else if (r_zero) begin
               n_sign = 1'b0; n_exp = '0; n_mant = '0;
            end else begin
               n_sign = s_big; n_exp = r_exp; n_mant = r_mant;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst || clr) begin
         acc_inf  <= 1'b0;
         acc_sign <= 1'b0;
         acc_exp  <= '0;
         acc_mant <= '0;
      end else begin
         acc_inf  <= n_inf;
         acc_sign <= n_sign;
         acc_exp  <= n_exp;
         acc_mant <= n_mant;
      end
   end
endmodule

// File: rtl/lns_mac.sv
module lns_mac
   import lns_mac_pkg::*;
#(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 16
)
(
   input  logic               clk,
   input  logic               rst,
   input  logic               clr,
   input  logic               in_valid,
   output logic               in_ready,
   input  logic [OP_W-1:0]    in_a,
   input  logic [OP_W-1:0]    in_b,
   input  logic               in_fmt_a,
   input  logic               in_fmt_b,
   input  logic               in_div,
   output logic               acc_valid,
   output logic               acc_inf,
   output logic               acc_sign,
   output logic [EXP_W-1:0]   acc_exp,
   output logic [FRAC_W:0]    acc_mant
);
   if (EXP_W < 8) begin : g_bad_exp
      $error("lns_mac: EXP_W must be at least 8");
   end
   if (FRAC_W < 16) begin : g_bad_frac
      $error("lns_mac: FRAC_W must be at least 16");
   end

   logic [OP_W-1:0] codes [2];
   logic            fmts  [2];
   opnd_t           dec   [2];

   assign codes[0] = in_a;
   assign codes[1] = in_b;
   assign fmts[0]  = in_fmt_a;
   assign fmts[1]  = in_fmt_b;

   for (genvar gi = 0; gi < 2; gi++) begin : g_dec
      lns_opnd_dec u_dec (
         .code (codes[gi]),
         .fmt  (fmts[gi]),
         .opnd (dec[gi])
      );
   end

   kind_t             c_kind;
   logic              c_sign;
   logic [EXP_W-1:0]  c_exp;
   logic [ROM_W-1:0]  c_mant;

   lns_prod #(.EXP_W(EXP_W)) u_prod (
      .a    (dec[0]),
      .b    (dec[1]),
      .div  (in_div),
      .kind (c_kind),
      .sign (c_sign),
      .exp  (c_exp),
      .mant (c_mant)
   );

   logic              accept;
   logic              p_valid;
   kind_t             p_kind;
   logic              p_sign;
   logic [EXP_W-1:0]  p_exp;
   logic [ROM_W-1:0]  p_mant;

   assign accept = in_valid && in_ready;

   always_ff @(posedge clk) begin
      if (rst) begin
         in_ready <= 1'b0;
         p_valid  <= 1'b0;
         p_kind   <= K_ZERO;
         p_sign   <= 1'b0;
         p_exp    <= '0;
         p_mant   <= '0;
      end else begin
         in_ready <= 1'b1;
         p_valid  <= accept;
         if (accept) begin
            p_kind <= c_kind;
            p_sign <= c_sign;
            p_exp  <= c_exp;
            p_mant <= c_mant;
         end
      end
   end

   assign acc_valid = !p_valid;

   lns_accum #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_acc (
      .clk      (clk),
      .rst      (rst),
      .clr      (clr),
      .p_valid  (p_valid),
      .p_kind   (p_kind),
      .p_sign   (p_sign),
      .p_exp    (p_exp),
      .p_mant   (p_mant),
      .acc_inf  (acc_inf),
      .acc_sign (acc_sign),
      .acc_exp  (acc_exp),
      .acc_mant (acc_mant)
   );
endmodule

// File: rtl/lns_mac_chk.sv
module lns_mac_chk #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 16
)
(
   input logic              clk,
   input logic              rst,
   input logic              clr,
   input logic              in_valid,
   input logic              in_ready,
   input logic [7:0]        in_a,
   input logic              acc_valid,
   input logic              acc_inf,
   input logic              acc_sign,
   input logic [EXP_W-1:0]  acc_exp,
   input logic [FRAC_W:0]   acc_mant
);
   // R11
   accept_hides_valid_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready) |=> !acc_valid);

   // R11
   idle_shows_valid_chk: assert property (@(posedge clk) disable iff (rst)
      !(in_valid && in_ready) |=> acc_valid);

   // R9
   inf_holds_chk: assert property (@(posedge clk) disable iff (rst)
      (acc_inf && !clr) |=> acc_inf);

   // R10
   clear_empties_chk: assert property (@(posedge clk) disable iff (rst)
      clr |=> (!acc_inf && acc_mant == '0));

   // R6
   mant_normal_chk: assert property (@(posedge clk) disable iff (rst)
      (acc_mant != '0) |-> acc_mant[FRAC_W]);

   // R6
   zero_form_chk: assert property (@(posedge clk) disable iff (rst)
      (acc_mant == '0) |-> (acc_exp == '0 && !acc_sign));

   // R5
   inf_operand_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready && in_a == 8'h80) ##1 !clr |=> acc_inf);
endmodule

bind lns_mac lns_mac_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .clr       (clr),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .in_a      (in_a),
   .acc_valid (acc_valid),
   .acc_inf   (acc_inf),
   .acc_sign  (acc_sign),
   .acc_exp   (acc_exp),
   .acc_mant  (acc_mant)
);

// File: tb/lns_mac_tb.sv
`timescale 1ns/1ps
module lns_mac_tb;
   localparam int EXP_W  = 8;
   localparam int FRAC_W = 16;
   localparam int BIAS   = 127;
   localparam int NV     = 19;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic clr = 1'b0;
   logic in_valid = 1'b0;
   logic [7:0] in_a = '0, in_b = '0;
   logic in_fmt_a = 1'b0, in_fmt_b = 1'b0, in_div = 1'b0;
   logic in_ready, acc_valid, acc_inf, acc_sign;
   logic [EXP_W-1:0] acc_exp;
   logic [FRAC_W:0]  acc_mant;

   always #4 clk = ~clk;

   lns_mac #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_dut (
      .clk(clk), .rst(rst), .clr(clr), .in_valid(in_valid), .in_ready(in_ready),
      .in_a(in_a), .in_b(in_b), .in_fmt_a(in_fmt_a), .in_fmt_b(in_fmt_b),
      .in_div(in_div), .acc_valid(acc_valid), .acc_inf(acc_inf),
      .acc_sign(acc_sign), .acc_exp(acc_exp), .acc_mant(acc_mant)
   );

   // mantissa table from R4
   localparam int ROMV [8] = '{64, 70, 76, 83, 91, 99, 108, 117};

   // kind: 0 number, 1 zero, 2 infinity
   function automatic logic [32:0] mk(logic [7:0] a, logic [7:0] b, logic fa,
                                      logic fb, logic dv, logic [1:0] kind,
                                      logic s, int e, int f);
      return {kind, s, 8'(e), 3'(f), dv, fb, fa, b, a};
   endfunction

   localparam logic [32:0] VEC [NV] = '{
      mk(8'h40, 8'h40, 0, 0, 0, 2'd0, 0,   0, 0),
      mk(8'hCB, 8'h42, 0, 0, 0, 2'd0, 1,   1, 5),
      mk(8'h30, 8'h4E, 0, 1, 0, 2'd0, 0,   1, 4),
      mk(8'h01, 8'h01, 1, 1, 0, 2'd0, 0, -32, 4),
      mk(8'hFF, 8'hFF, 1, 1, 0, 2'd0, 0,  31, 4),
      mk(8'h42, 8'h40, 0, 0, 0, 2'd0, 0,   0, 2),
      mk(8'h43, 8'h40, 0, 0, 0, 2'd0, 0,   0, 3),
      mk(8'h46, 8'h40, 0, 0, 0, 2'd0, 0,   0, 6),
      mk(8'h47, 8'h40, 0, 0, 0, 2'd0, 0,   0, 7),
      mk(8'h50, 8'hC3, 0, 0, 1, 2'd0, 1,   1, 5),
      mk(8'h40, 8'h4F, 1, 0, 1, 2'd0, 0,  -2, 1),
      mk(8'h00, 8'h4B, 0, 0, 0, 2'd1, 0,   0, 0),
      mk(8'h80, 8'h40, 0, 0, 0, 2'd2, 0,   0, 0),
      mk(8'h00, 8'h80, 0, 0, 0, 2'd2, 0,   0, 0),
      mk(8'h40, 8'h00, 0, 0, 1, 2'd2, 0,   0, 0),
      mk(8'h40, 8'h80, 0, 0, 1, 2'd1, 0,   0, 0),
      mk(8'h00, 8'h00, 0, 0, 1, 2'd2, 0,   0, 0),
      mk(8'h80, 8'h80, 0, 0, 1, 2'd2, 0,   0, 0),
      mk(8'h4E, 8'h00, 1, 1, 0, 2'd1, 0,   0, 0)
   };

   int  n_chk = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;

   task automatic check(string tag, logic xi, logic xs, int xe, int xm);
      n_chk++;
      if (acc_inf !== xi || acc_sign !== xs || int'(acc_exp) != xe || int'(acc_mant) != xm) begin
         n_bad++;
         $display("FAIL %s: got inf=%0b sign=%0b exp=%0d mant=%0d, expected inf=%0b sign=%0b exp=%0d mant=%0d",
                  tag, acc_inf, acc_sign, acc_exp, acc_mant, xi, xs, xe, xm);
      end
   endtask

   task automatic check_bit(string tag, logic got, logic want);
      n_chk++;
      if (got !== want) begin
         n_bad++;
         $display("FAIL %s: got %0b expected %0b", tag, got, want);
      end
   endtask

   // drive one pair before the next edge; returns after that edge
   task automatic push(logic [7:0] a, logic [7:0] b, logic fa, logic fb,
                       logic dv, logic c);
      in_a = a; in_b = b; in_fmt_a = fa; in_fmt_b = fb; in_div = dv;
      in_valid = 1'b1; clr = c;
      @(negedge clk);
      in_valid = 1'b0; clr = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R12 reset state, R11 ready
      check("R12 reset sum", 1'b0, 1'b0, 0, 0);
      check_bit("R12 acc_valid after reset", acc_valid, 1'b1);
      check_bit("R11 in_ready after reset", in_ready, 1'b1);

      // table: each vector cleared together with its pair (R10)
      for (int i = 0; i < NV; i++) begin
         logic [32:0] v;
         string tg;
         int e, f, k;
         v = VEC[i];
         e = int'($signed(v[29:22]));
         f = int'(v[21:19]);
         k = int'(v[32:31]);
         push(v[7:0], v[15:8], v[16], v[17], v[18], 1'b1);
         @(negedge clk);
         if (k == 2)      tg = $sformatf("R5 R10 vector %0d", i);
         else if (k == 1) tg = $sformatf("R5 R6 vector %0d", i);
         else if (v[18])  tg = $sformatf("R3 R4 vector %0d", i);
         else             tg = $sformatf("R1 R2 R4 vector %0d", i);
         if (k == 2)      check(tg, 1'b1, 1'b0, 0, 0);
         else if (k == 1) check(tg, 1'b0, 1'b0, 0, 0);
         else             check(tg, 1'b0, v[30], e + BIAS, ROMV[f] << (FRAC_W - 6));
      end

      // R7 dot product 1 + 2 - 0.5 + 4 = 6.5, R11 valid timing
      push(8'h40, 8'h40, 0, 0, 0, 1'b1);
      check_bit("R11 acc_valid low after accept", acc_valid, 1'b0);
      push(8'h48, 8'h40, 0, 0, 0, 1'b0);
      push(8'hB8, 8'h40, 0, 0, 0, 1'b0);
      push(8'h50, 8'h40, 0, 0, 0, 1'b0);
      @(negedge clk);
      check_bit("R11 acc_valid high when idle", acc_valid, 1'b1);
      check("R7 dot product 6.5", 1'b0, 1'b0, BIAS + 2, 106496);

      // R7 cancellation 1 + (-1)
      push(8'h40, 8'h40, 0, 0, 0, 1'b1);
      push(8'hC0, 8'h40, 0, 0, 0, 1'b0);
      @(negedge clk);
      check("R7 cancel to zero", 1'b0, 1'b0, 0, 0);

      // R8 ties to even: 1 + 2^-17 stays 1
      push(8'h40, 8'h40, 0, 0, 0, 1'b1);
      push(8'h04, 8'h1A, 0, 1, 0, 1'b0);
      @(negedge clk);
      check("R8 tie keeps even", 1'b0, 1'b0, BIAS, 65536);
      push(8'h04, 8'h1E, 0, 1, 0, 1'b0);
      @(negedge clk);
      check("R8 exact ulp add", 1'b0, 1'b0, BIAS, 65537);
      push(8'h04, 8'h1A, 0, 1, 0, 1'b0);
      @(negedge clk);
      check("R8 tie rounds odd up", 1'b0, 1'b0, BIAS, 65538);

      // R9 infinity stays
      push(8'h40, 8'h40, 0, 0, 0, 1'b1);
      push(8'h80, 8'h40, 0, 0, 0, 1'b0);
      push(8'h40, 8'h40, 0, 0, 0, 1'b0);
      push(8'h00, 8'h40, 0, 0, 0, 1'b0);
      @(negedge clk);
      check("R9 infinity held", 1'b1, 1'b0, 0, 0);
      clr = 1'b1;
      @(negedge clk);
      clr = 1'b0;
      check("R9 R10 clear leaves infinity", 1'b0, 1'b0, 0, 0);

      // R10 clear discards in-flight product, keeps same-cycle pair
      push(8'h40, 8'h40, 0, 0, 0, 1'b0);
      push(8'h48, 8'h40, 0, 0, 0, 1'b1);
      @(negedge clk);
      check("R10 in-flight discarded", 1'b0, 1'b0, BIAS + 1, 65536);

      done = 1'b1;
   end

   initial begin
      for (int c = 0; c < 200000 && !done; c++) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got hung run, expected completion");
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule